// File: doc/BRIEF.md
# Thermometer scratchpad command controller

This block is the function-command layer of a digital thermometer that sits on a single-wire bus as a slave. A bit-slot layer below it delivers whole bytes from the master and a pulse for each bus reset. When the master starts a read slot, the slot layer raises a request, and the block answers one cycle later with either a byte or a single status bit. ROM addressing has already been done below this block. The first byte after each bus reset is therefore taken as a function command.

The block holds a nine-byte scratchpad. It contains the measured temperature, a high and a low alarm threshold, a resolution byte, three fixed bytes and a CRC over the first eight bytes. A shadow copy of the thresholds and the resolution stands in for nonvolatile storage. A convert command starts a timed conversion whose length depends on the resolution. When the conversion ends, the block takes the sensor word from an input, clears the low bits that the resolution leaves undefined, and re-evaluates the alarm flag. Copy moves the threshold and resolution bytes into the shadow set. Recall moves them back. A power query reports whether the device is fed from the data line.

Top module: `thermo_cmd_ctrl`

## Requirements
- R1: After `rst_n` is released, the scratchpad reads 50h 05h (temperature 0550h, least significant byte first). It then holds the shadow power-up thresholds, high 4Bh and low 46h by default. The resolution is 12 bits, and `alarm`, `busy`, `wr_partial` and `rd_valid` are all 0.
- R2: Command BEh makes successive read requests return scratchpad bytes 0 to 8 in order. Byte 5 is FFh, byte 6 is the `RSVD6` parameter (00h by default) and byte 7 is 10h. Any read after byte 8 returns FFh. Each read request is answered by `rd_valid` exactly one cycle later.
- R3: Command 4Eh takes exactly three data bytes, in this order: high threshold (byte 2), low threshold (byte 3), resolution byte (byte 4). Only bits 6:5 of the resolution byte are stored. That byte always reads back with bit 7 = 0 and bits 4:0 = 1.
- R4: Scratchpad byte 8 is the CRC-8 of bytes 0 to 7. It uses polynomial x^8+x^5+x^4+1 with a zero start value, and bits are fed least significant bit first starting from byte 0.
- R5: Command 44h sets `busy` for `CONV_CYC/8`, `/4`, `/2` or `CONV_CYC` cycles, for resolution code 0, 1, 2 or 3 respectively. Read requests during that time return a status bit (`rd_is_bit` = 1) that is 0 while busy and 1 once done. The temperature changes only at the end of a conversion.
- R6: At the end of a conversion, temperature bits below the resolution are cleared: three bits at code 0, two at code 1, one at code 2, none at code 3.
- R7: At the end of each conversion, `alarm` is set to whether temperature bits 11:4, taken as a signed byte, are ≤ the low threshold or ≥ the high threshold. Both comparisons are signed.
- R8: Command 48h copies bytes 2 to 4 into the shadow set and sets `busy` for `COPY_CYC` cycles.
- R9: Command B8h sets `busy` for `RECALL_CYC` cycles. At its end it restores bytes 2 to 4 from the shadow set. Read requests meanwhile return status bits, 0 while busy and 1 when done.
- R10: After command B4h, a read request returns status bit 0 when `parasite` is 1 and 1 when it is 0.
- R11: A bus reset returns the block to waiting for a command, so a later BEh restarts the read at byte 0. A 4Eh that is cut short by a reset leaves `wr_partial` at 1. A complete three-byte write or a finished recall clears it.
- R12: After an unknown opcode, every further byte is ignored until a bus reset, reads return FFh, and the scratchpad is unchanged.
- R13: A convert, copy or recall issued while `busy` is 1 is ignored. The running operation keeps its length and the shadow set is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, equivalent to power-up |
| bus_reset | input | 1 | One-cycle pulse: reset seen on the bus |
| rx_valid | input | 1 | One-cycle pulse: `rx_byte` holds a byte written by the master |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | One-cycle pulse: master starts a read |
| temp_in | input | 16 | Sensor word, two's complement in 1/16 °C steps |
| parasite | input | 1 | 1 when the device is powered from the data line |
| rd_valid | output | 1 | Answer to the read request of the previous cycle |
| rd_data | output | 8 | Byte to send, or the status in bit 0 |
| rd_is_bit | output | 1 | 1 when only `rd_data[0]` is a status bit |
| busy | output | 1 | Conversion, copy or recall in progress |
| alarm | output | 1 | Alarm flag from the last conversion |
| wr_partial | output | 1 | Last scratchpad write was cut short |

## Verification
The bench goes after the resolution corners. If the shift is off by one, the busy length and the masked temperature both go wrong at 9 and 10 bits. A threshold compare done unsigned would miss the negative-temperature alarms. The equal-to-threshold vectors catch a strict compare. Fixed bits of the resolution byte are written as ones and zeros, so a design that stored them would read them back. Recall after a rewritten scratchpad shows whether copy really wrote the shadow set. Commands issued mid-conversion check that a busy block neither restarts its timer nor copies. A read cut by a reset, a write cut by a reset, and bytes after an unknown opcode catch an FSM that fails to resynchronise.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

  localparam logic [7:0] OPC_CONVERT = 8'h44;
  localparam logic [7:0] OPC_RD_PAD  = 8'hBE;
  localparam logic [7:0] OPC_WR_PAD  = 8'h4E;
  localparam logic [7:0] OPC_COPY    = 8'h48;
  localparam logic [7:0] OPC_RECALL  = 8'hB8;
  localparam logic [7:0] OPC_PWR     = 8'hB4;

  localparam int PAD_BYTES = 9;
  localparam int PAD_DATA  = PAD_BYTES - 1;

  typedef enum logic [2:0] {
    ST_CMD, ST_WRITE, ST_READ, ST_STATUS, ST_POWER, ST_HOLD
  } cmd_state_t;

  typedef enum logic [1:0] {
    OP_IDLE, OP_CONV, OP_COPY, OP_RECALL
  } op_kind_t;

  // clear the bits a coarser resolution leaves undefined
  function automatic logic [15:0] res_mask(input logic [15:0] t, input logic [1:0] res);
    logic [15:0] m;
    m = 16'hFFFF << (2'd3 - res);
    return t & m;
  endfunction

  // signed compare of temperature bits 11:4 against both thresholds
  function automatic logic alarm_hit(input logic [15:0] t, input logic [7:0] th,
                                     input logic [7:0] tl);
    logic signed [7:0] s;
    s = t[11:4];
    return (s <= $signed(tl)) || (s >= $signed(th));
  endfunction

  // one byte through the reflected x^8+x^5+x^4+1 CRC, lsb first
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
    logic [7:0] c;
    logic       fb;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [7:0] cfg_image(input logic [1:0] res);
    return {1'b0, res, 5'b11111};
  endfunction

endpackage

// File: rtl/thermo_op_timer.sv
module thermo_op_timer
  import thermo_pkg::*;
#(
  parameter int CONV_CYC   = 160,
  parameter int COPY_CYC   = 50,
  parameter int RECALL_CYC = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  op_kind_t start_op,
  input  logic [1:0] res,
  output logic     busy,
  output op_kind_t cur_op,
  output logic     fire
);

  localparam int MAX_A  = (CONV_CYC > COPY_CYC) ? CONV_CYC : COPY_CYC;
  localparam int MAX_C  = (MAX_A > RECALL_CYC) ? MAX_A : RECALL_CYC;
  localparam int CW     = $clog2(MAX_C + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_len;
  op_kind_t      op_q;

  always_comb begin
    load_len = '0;
    case (start_op)
      OP_CONV: begin
        case (res)
          2'd0:    load_len = CW'(CONV_CYC / 8);
          2'd1:    load_len = CW'(CONV_CYC / 4);
          2'd2:    load_len = CW'(CONV_CYC / 2);
          default: load_len = CW'(CONV_CYC);
        endcase
      end
      OP_COPY:   load_len = CW'(COPY_CYC);
      OP_RECALL: load_len = CW'(RECALL_CYC);
      default:   load_len = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      op_q  <= OP_IDLE;
    end else if (start) begin
      cnt_q <= load_len;
      op_q  <= start_op;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) op_q <= OP_IDLE;
    end
  end

  assign busy   = (cnt_q != '0);
  assign fire   = (cnt_q == CW'(1));
  assign cur_op = op_q;

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R13
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R5
  AST_OP_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_op)); // R13

endmodule

// File: rtl/thermo_pad_crc.sv
module thermo_pad_crc
  import thermo_pkg::*;
#(
  parameter int N_BYTES = PAD_DATA
) (
  input  logic [N_BYTES-1:0][7:0] data,
  output logic [7:0]              crc
);

  always_comb begin
    crc = '0;
    for (int i = 0; i < N_BYTES; i++) crc = crc8_step(crc, data[i]);
  end

endmodule

// File: rtl/thermo_scratchpad.sv
module thermo_scratchpad
  import thermo_pkg::*;
#(
  parameter logic [15:0] TEMP_INIT   = 16'h0550,
  parameter logic [7:0]  NV_TH_INIT  = 8'h4B,
  parameter logic [7:0]  NV_TL_INIT  = 8'h46,
  parameter logic [1:0]  NV_RES_INIT = 2'd3,
  parameter logic [7:0]  RSVD5       = 8'hFF,
  parameter logic [7:0]  RSVD6       = 8'h00,
  parameter logic [7:0]  RSVD7       = 8'h10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  logic [7:0]               wr_data,
  input  logic                     conv_fire,
  input  logic [15:0]              temp_in,
  input  logic                     copy_start,
  input  logic                     recall_fire,
  output logic [PAD_DATA-1:0][7:0] pad_lo,
  output logic [1:0]               res,
  output logic                     alarm
);

  logic [15:0] temp_q;
  logic [7:0]  th_q, tl_q;
  logic [1:0]  res_q;
  logic [7:0]  nv_th_q, nv_tl_q;
  logic [1:0]  nv_res_q;
  logic        alarm_q;
  logic [15:0] temp_masked;

  assign temp_masked = res_mask(temp_in, res_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q  <= TEMP_INIT;
      alarm_q <= 1'b0;
    end else if (conv_fire) begin
      temp_q  <= temp_masked;
      alarm_q <= alarm_hit(temp_masked, th_q, tl_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      th_q  <= NV_TH_INIT;
      tl_q  <= NV_TL_INIT;
      res_q <= NV_RES_INIT;
    end else if (recall_fire) begin
      th_q  <= nv_th_q;
      tl_q  <= nv_tl_q;
      res_q <= nv_res_q;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0:    th_q  <= wr_data;
        2'd1:    tl_q  <= wr_data;
        2'd2:    res_q <= wr_data[6:5];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_th_q  <= NV_TH_INIT;
      nv_tl_q  <= NV_TL_INIT;
      nv_res_q <= NV_RES_INIT;
    end else if (copy_start) begin
      nv_th_q  <= th_q;
      nv_tl_q  <= tl_q;
      nv_res_q <= res_q;
    end
  end

  assign pad_lo[0] = temp_q[7:0];
  assign pad_lo[1] = temp_q[15:8];
  assign pad_lo[2] = th_q;
  assign pad_lo[3] = tl_q;
  assign pad_lo[4] = cfg_image(res_q);
  assign pad_lo[5] = RSVD5;
  assign pad_lo[6] = RSVD6;
  assign pad_lo[7] = RSVD7;
  assign res       = res_q;
  assign alarm     = alarm_q;

  AST_TEMP_ONLY_ON_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(temp_q) |-> $past(conv_fire)); // R5
  AST_ALARM_ONLY_ON_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alarm_q) |-> $past(conv_fire)); // R7
  AST_NV_ONLY_ON_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(nv_th_q) || !$stable(nv_tl_q) || !$stable(nv_res_q)) |-> $past(copy_start)); // R8

endmodule

// File: rtl/thermo_cmd_ctrl.sv
module thermo_cmd_ctrl
  import thermo_pkg::*;
#(
  parameter int          CONV_CYC    = 160,
  parameter int          COPY_CYC    = 50,
  parameter int          RECALL_CYC  = 6,
  parameter logic [7:0]  NV_TH_INIT  = 8'h4B,
  parameter logic [7:0]  NV_TL_INIT  = 8'h46,
  parameter logic [1:0]  NV_RES_INIT = 2'd3,
  parameter logic [7:0]  RSVD6       = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_reset,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rd_req,
  input  logic [15:0] temp_in,
  input  logic        parasite,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic        rd_is_bit,
  output logic        busy,
  output logic        alarm,
  output logic        wr_partial
);

  localparam int IDX_W = $clog2(PAD_BYTES + 1);

  cmd_state_t state_q, state_nx;
  logic [1:0]       wr_cnt_q;
  logic [IDX_W-1:0] rd_idx_q;
  logic             wr_partial_q;
  logic             rd_valid_q, rd_is_bit_q;
  logic [7:0]       rd_data_q;

  // named internal events
  logic     cmd_fire, data_fire;
  logic     op_start;
  op_kind_t op_kind;
  logic     tmr_busy, tmr_fire;
  op_kind_t tmr_op;
  logic     conv_fire, recall_fire, copy_start;
  logic [1:0] res;

  logic [PAD_DATA-1:0][7:0]  pad_lo;
  logic [PAD_BYTES-1:0][7:0] pad_all;
  logic [7:0]                crc_byte;
  logic [7:0]                pad_pick;

  assign cmd_fire  = rx_valid && !bus_reset && (state_q == ST_CMD);
  assign data_fire = rx_valid && !bus_reset && (state_q == ST_WRITE);

  always_comb begin
    op_start = 1'b0;
    op_kind  = OP_IDLE;
    state_nx = ST_HOLD;
    case (rx_byte)
      OPC_CONVERT: if (!tmr_busy) begin
        op_start = 1'b1;
        op_kind  = OP_CONV;
        state_nx = ST_STATUS;
      end
      OPC_RECALL: if (!tmr_busy) begin
        op_start = 1'b1;
        op_kind  = OP_RECALL;
        state_nx = ST_STATUS;
      end
      OPC_COPY: if (!tmr_busy) begin
        op_start = 1'b1;
        op_kind  = OP_COPY;
      end
      OPC_RD_PAD: state_nx = ST_READ;
      OPC_WR_PAD: state_nx = ST_WRITE;
      OPC_PWR:    state_nx = ST_POWER;
      default:    state_nx = ST_HOLD;
    endcase
    if (!cmd_fire) op_start = 1'b0;
  end

  assign copy_start  = op_start && (op_kind == OP_COPY);
  assign conv_fire   = tmr_fire && (tmr_op == OP_CONV);
  assign recall_fire = tmr_fire && (tmr_op == OP_RECALL);

  thermo_op_timer #(
    .CONV_CYC  (CONV_CYC),
    .COPY_CYC  (COPY_CYC),
    .RECALL_CYC(RECALL_CYC)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (op_start),
    .start_op(op_kind),
    .res     (res),
    .busy    (tmr_busy),
    .cur_op  (tmr_op),
    .fire    (tmr_fire)
  );

  thermo_scratchpad #(
    .NV_TH_INIT (NV_TH_INIT),
    .NV_TL_INIT (NV_TL_INIT),
    .NV_RES_INIT(NV_RES_INIT),
    .RSVD6      (RSVD6)
  ) u_pad (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (data_fire),
    .wr_sel     (wr_cnt_q),
    .wr_data    (rx_byte),
    .conv_fire  (conv_fire),
    .temp_in    (temp_in),
    .copy_start (copy_start),
    .recall_fire(recall_fire),
    .pad_lo     (pad_lo),
    .res        (res),
    .alarm      (alarm)
  );

  thermo_pad_crc #(.N_BYTES(PAD_DATA)) u_crc (
    .data(pad_lo),
    .crc (crc_byte)
  );

  assign pad_all  = {crc_byte, pad_lo};
  assign pad_pick = (rd_idx_q < IDX_W'(PAD_BYTES)) ? pad_all[rd_idx_q] : 8'hFF;

  // command / data sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_CMD;
      wr_cnt_q     <= '0;
      wr_partial_q <= 1'b0;
    end else begin
      if (recall_fire) wr_partial_q <= 1'b0;
      if (bus_reset) begin
        state_q <= ST_CMD;
      end else if (cmd_fire) begin
        state_q  <= state_nx;
        wr_cnt_q <= '0;
        if (rx_byte == OPC_WR_PAD) wr_partial_q <= 1'b1;
      end else if (data_fire) begin
        wr_cnt_q <= wr_cnt_q + 2'd1;
        if (wr_cnt_q == 2'd2) begin
          state_q      <= ST_HOLD;
          wr_partial_q <= 1'b0;
        end
      end
    end
  end

  // read answers, one cycle after each request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx_q    <= '0;
      rd_valid_q  <= 1'b0;
      rd_data_q   <= 8'hFF;
      rd_is_bit_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_req;
      if (cmd_fire) rd_idx_q <= '0;
      if (rd_req) begin
        rd_is_bit_q <= 1'b0;
        rd_data_q   <= 8'hFF;
        case (state_q)
          ST_READ: begin
            rd_data_q <= pad_pick;
            if (rd_idx_q < IDX_W'(PAD_BYTES) && !bus_reset) rd_idx_q <= rd_idx_q + IDX_W'(1);
          end
          ST_STATUS: begin
            rd_is_bit_q <= 1'b1;
            rd_data_q   <= {7'd0, !tmr_busy};
          end
          ST_POWER: begin
            rd_is_bit_q <= 1'b1;
            rd_data_q   <= {7'd0, !parasite};
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_valid   = rd_valid_q;
  assign rd_data    = rd_data_q;
  assign rd_is_bit  = rd_is_bit_q;
  assign busy       = tmr_busy;
  assign wr_partial = wr_partial_q;

  AST_RD_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid); // R2
  AST_RD_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx_q <= IDX_W'(PAD_BYTES)); // R2
  AST_WR_THREE_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && wr_cnt_q == 2'd2) |=> (state_q != ST_WRITE)); // R3
  AST_PARTIAL_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && state_q == ST_WRITE) |=> (wr_partial || $past(recall_fire))); // R11
  AST_UNKNOWN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !bus_reset) |=> (state_q == ST_HOLD)); // R12

endmodule

// File: tb/thermo_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module thermo_cmd_ctrl_tb_top;

  localparam int CONV_CYC   = 160;
  localparam int COPY_CYC   = 50;
  localparam int RECALL_CYC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_reset = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        rd_req = 1'b0;
  logic [15:0] temp_in = 16'h0000;
  logic        parasite = 1'b0;
  logic        rd_valid, rd_is_bit, busy, alarm, wr_partial;
  logic [7:0]  rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  thermo_cmd_ctrl #(
    .CONV_CYC(CONV_CYC), .COPY_CYC(COPY_CYC), .RECALL_CYC(RECALL_CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rd_req(rd_req), .temp_in(temp_in), .parasite(parasite),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_is_bit(rd_is_bit),
    .busy(busy), .alarm(alarm), .wr_partial(wr_partial)
  );

  typedef struct packed {
    logic [1:0]  res;
    logic [15:0] tin;
    logic [7:0]  th;
    logic [7:0]  tl;
    logic [15:0] exp_t;
    logic        exp_al;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd3, 16'h0191, 8'h1E, 8'h0A, 16'h0191, 1'b0},
    '{2'd3, 16'h07D0, 8'h7D, 8'h00, 16'h07D0, 1'b1},
    '{2'd0, 16'h0191, 8'h1E, 8'h0A, 16'h0190, 1'b0},
    '{2'd1, 16'hFF5E, 8'h05, 8'hF5, 16'hFF5C, 1'b1},
    '{2'd2, 16'hFE6F, 8'h19, 8'hE5, 16'hFE6E, 1'b0},
    '{2'd3, 16'hFC90, 8'h7F, 8'hC9, 16'hFC90, 1'b1},
    '{2'd3, 16'h0008, 8'h01, 8'hFF, 16'h0008, 1'b0},
    '{2'd2, 16'h0000, 8'h00, 8'h80, 16'h0000, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // shift-register form of the scratchpad CRC
  function automatic logic [7:0] bench_crc(input logic [7:0][7:0] b);
    logic [7:0] sr;
    logic fb;
    sr = 8'h00;
    for (int j = 0; j < 8; j++)
      for (int i = 0; i < 8; i++) begin
        fb = sr[0] ^ b[j][i];
        sr = {fb, sr[7:1]};
        sr[3] = sr[3] ^ fb;
        sr[2] = sr[2] ^ fb;
      end
    return sr;
  endfunction

  function automatic int conv_len(input logic [1:0] res);
    return CONV_CYC / (1 << (3 - int'(res)));
  endfunction

  task automatic send_byte(input logic [7:0] b);
    rx_byte = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse_reset();
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
  endtask

  task automatic read_one(output logic [7:0] d, output logic isb);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    d = rd_data; isb = rd_is_bit;
  endtask

  task automatic read_pad(output logic [8:0][7:0] p);
    logic isb;
    pulse_reset();
    send_byte(8'hBE);
    for (int i = 0; i < 9; i++) read_one(p[i], isb);
  endtask

  task automatic write_pad(input logic [7:0] th, input logic [7:0] tl, input logic [7:0] cfg);
    pulse_reset();
    send_byte(8'h4E); send_byte(th); send_byte(tl); send_byte(cfg);
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (busy && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [8:0][7:0] p, q;
    logic [7:0] d;
    logic isb;
    int n;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", 32'(busy), 0);
    check("R1 alarm", 32'(alarm), 0);
    check("R1 wr_partial", 32'(wr_partial), 0);
    check("R1 rd_valid", 32'(rd_valid), 0);
    read_pad(p);
    check("R1 temp", {16'd0, p[1], p[0]}, 32'h0550);
    check("R1 th", 32'(p[2]), 32'h4B);
    check("R1 tl", 32'(p[3]), 32'h46);
    check("R3 cfg reset", 32'(p[4]), 32'h7F);
    check("R2 byte5", 32'(p[5]), 32'hFF);
    check("R2 byte6", 32'(p[6]), 32'h00);
    check("R2 byte7", 32'(p[7]), 32'h10);
    check("R4 crc reset", 32'(p[8]), 32'(bench_crc(p[7:0])));
    read_one(d, isb);
    check("R2 past end", {23'd0, isb, d}, 32'h0FF);
    check("R2 rd_valid", 32'(rd_valid), 1);

    // vector table: R3 R4 R5 R6 R7
    foreach (VECS[k]) begin
      write_pad(VECS[k].th, VECS[k].tl, {1'b1, VECS[k].res, 5'b00000});
      temp_in = VECS[k].tin;
      pulse_reset();
      send_byte(8'h44);
      wait_busy(n);
      check($sformatf("R5 conv len v%0d", k), 32'(n), 32'(conv_len(VECS[k].res)));
      read_pad(p);
      check($sformatf("R6 temp v%0d", k), {16'd0, p[1], p[0]}, 32'(VECS[k].exp_t));
      check($sformatf("R7 alarm v%0d", k), 32'(alarm), 32'(VECS[k].exp_al));
      check($sformatf("R3 th v%0d", k), 32'(p[2]), 32'(VECS[k].th));
      check($sformatf("R3 tl v%0d", k), 32'(p[3]), 32'(VECS[k].tl));
      check($sformatf("R3 cfg v%0d", k), 32'(p[4]), 32'({1'b0, VECS[k].res, 5'b11111}));
      check($sformatf("R4 crc v%0d", k), 32'(p[8]), 32'(bench_crc(p[7:0])));
    end

    // R5 status bits during a conversion
    write_pad(8'h40, 8'hC0, 8'h00);
    temp_in = 16'h0123;
    pulse_reset();
    send_byte(8'h44);
    read_one(d, isb);
    check("R5 status busy", {23'd0, isb, d}, 32'h100);
    wait_busy(n);
    read_one(d, isb);
    check("R5 status done", {23'd0, isb, d}, 32'h101);

    // R8 copy, R9 recall
    write_pad(8'h11, 8'h22, 8'h20);
    pulse_reset();
    send_byte(8'h48);
    wait_busy(n);
    check("R8 copy len", 32'(n), 32'(COPY_CYC));
    write_pad(8'h33, 8'h44, 8'h60);
    pulse_reset();
    send_byte(8'hB8);
    read_one(d, isb);
    check("R9 recall busy bit", {23'd0, isb, d}, 32'h100);
    wait_busy(n);
    check("R9 recall len", 32'(n), 32'(RECALL_CYC - 1));
    read_one(d, isb);
    check("R9 recall done bit", {23'd0, isb, d}, 32'h101);
    read_pad(p);
    check("R9 th restored", 32'(p[2]), 32'h11);
    check("R8 tl copied", 32'(p[3]), 32'h22);
    check("R9 cfg restored", 32'(p[4]), 32'h3F);

    // R10 power query
    parasite = 1'b1;
    pulse_reset(); send_byte(8'hB4); read_one(d, isb);
    check("R10 parasite", {23'd0, isb, d}, 32'h100);
    parasite = 1'b0;
    pulse_reset(); send_byte(8'hB4); read_one(d, isb);
    check("R10 external", {23'd0, isb, d}, 32'h101);

    // R11 partial write, restarted read
    pulse_reset(); send_byte(8'h4E); send_byte(8'h77); pulse_reset();
    check("R11 partial flag", 32'(wr_partial), 1);
    write_pad(8'h12, 8'h34, 8'h60);
    check("R11 full write clears", 32'(wr_partial), 0);
    read_pad(p);
    check("R11 th after full", 32'(p[2]), 32'h12);
    pulse_reset(); send_byte(8'hBE); read_one(d, isb); read_one(d, isb);
    pulse_reset(); send_byte(8'hBE); read_one(d, isb);
    check("R11 read restarts", 32'(d), 32'(p[0]));

    // R12 unknown opcode
    read_pad(p);
    pulse_reset();
    send_byte(8'hA5); send_byte(8'h4E); send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
    read_one(d, isb);
    check("R12 read after unknown", {23'd0, isb, d}, 32'h0FF);
    read_pad(q);
    check("R12 pad unchanged", 32'(p == q), 1);

    // R13 commands while busy
    temp_in = 16'h0250;
    pulse_reset(); send_byte(8'h44);
    pulse_reset(); send_byte(8'h44);
    pulse_reset(); send_byte(8'h48);
    wait_busy(n);
    check("R13 conv not restarted", 32'(n), 32'(CONV_CYC - 4));
    pulse_reset(); send_byte(8'hB8);
    wait_busy(n);
    read_pad(p);
    check("R13 copy ignored th", 32'(p[2]), 32'h11);
    check("R13 temp once", {16'd0, p[1], p[0]}, 32'h0250);

    done_flag = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule